// File: doc/BRIEF.md
# Glitch-Free Clock Output Gate with Power Management

This block sits between a running synthesized clock and the output pad driver and decides when that clock reaches the pin. A single control pin is interpreted according to a configuration mode bit. In output-enable mode the pin is active high, and the oscillator and PLL keep running while the output is off. In power-down mode the pin is active low, and a low level also asks the oscillator and PLL to enter a low-current standby. In either mode a disabled output has its driver turned off (tri-state) and a weak pull-down turned on.

A second configuration bit selects how disabling is timed. With the asynchronous setting, the control pin cuts the gate at once, wherever the clock is in its cycle. With the synchronous setting, the request passes through a synchronizer, and the gate closes only at the next falling edge of the clock, so no runt pulse reaches the pin. Enabling is always synchronous: the gate opens only at a falling edge. When the block leaves power-down, it first waits for a lock-valid input from the PLL before that falling-edge enable.

Top module: `glitchfree_oe_ctl`

## Requirements
- R1: While `rst` is high, `drv_en` is 0, `pull_en` is 1, `standby_req` is 0 and `clk_out` is 0.
- R2: With `mode_pd`=0 (output-enable mode), `ctl_pin`=1 enables the output and `ctl_pin`=0 disables it. `standby_req` stays 0 and `lock_ok` has no effect.
- R3: With `mode_pd`=1 (power-down mode), `ctl_pin`=0 drives `standby_req` to 1 and disables the output.
- R4: When the pin leaves power-down, `standby_req` returns to 0, and the output stays disabled for as long as `lock_ok` is 0. After `lock_ok` rises, the output enables. A new power-down request that reaches the state machine in the same cycle as `lock_ok` takes priority, and the block returns to standby.
- R5: Whenever the output is disabled, `pull_en` is 1, `drv_en` is 0 and `clk_out` is held at 0. Whenever it is enabled, `clk_out` follows `osc_clk`.
- R6: With `timing_async`=1, a low `ctl_pin` clears `drv_en` and `clk_out` immediately, with no clock edge needed, even while `osc_clk` is high.
- R7: With `timing_async`=0, disabling happens only at a falling edge of `osc_clk`. `clk_out` never shows a high pulse shorter than the high time of `osc_clk`.
- R8: `drv_en` rises only while `osc_clk` is low (at a falling edge), in both timing settings.
- R9: On the synchronous path (two synchronizer stages by default), a change of `ctl_pin` leaves `drv_en` unchanged at the next rising edge of `osc_clk` and has taken effect within five `osc_clk` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Running synthesized clock; also the block's clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_pin | input | 1 | External control pin, polarity set by the mode |
| mode_pd | input | 1 | 0: output-enable mode, 1: power-down mode |
| timing_async | input | 1 | 0: disable at falling edge, 1: disable immediately |
| lock_ok | input | 1 | PLL lock valid, gates enable after power-down |
| clk_out | output | 1 | Gated clock toward the pad |
| drv_en | output | 1 | Pad driver enable (0 = tri-state) |
| pull_en | output | 1 | Weak pull-down enable |
| standby_req | output | 1 | Oscillator/PLL low-current standby request |

## Verification
Two functions of this block can act on the gate in the same cycle. The first pair is an asynchronous kill and the falling-edge enable. A kill pulse is placed in the high phase of `osc_clk`, short enough that the synchronizer never sees it. The bench then judges that the gate dropped at once and reopened only with `osc_clk` low. The second pair is a renewed power-down request and a rising `lock_ok` in the relock state. The pin is lowered two cycles before `lock_ok` is raised, so both reach the state machine at the same edge. The bench expects standby to win and the output to stay off.

// File: rtl/oe_ctl_pkg.sv
package oe_ctl_pkg;

    typedef enum logic {
        MODE_OE = 1'b0,
        MODE_PD = 1'b1
    } pm_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ON     = 2'd1,
        ST_SLEEP  = 2'd2,
        ST_RELOCK = 2'd3
    } gate_state_e;

    typedef struct packed {
        logic off;
        logic sleep;
    } ctl_req_t;

    typedef struct packed {
        logic want_on;
        logic standby;
    } gate_ctl_t;

    localparam int unsigned DEF_SYNC_STAGES = 2;

    // Both modes disable on a low pin; only power-down mode also sleeps.
    function automatic ctl_req_t decode_pin(logic pin_level, pm_mode_e mode);
        ctl_req_t r;
        r.off   = !pin_level;
        r.sleep = !pin_level && (mode == MODE_PD);
        return r;
    endfunction

endpackage

// File: rtl/oe_sync.sv
module oe_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic osc_clk,
    input  logic rst,
    input  logic d_in,
    output logic q_out
);
    localparam int unsigned LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge osc_clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge osc_clk) begin
                    if (rst) chain_q[i] <= 1'b0;
                    else     chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign q_out = chain_q[LAST];
endmodule

// File: rtl/oe_mode_fsm.sv
module oe_mode_fsm
    import oe_ctl_pkg::*;
(
    input  logic      osc_clk,
    input  logic      rst,
    input  pm_mode_e  mode,
    input  ctl_req_t  req,
    input  logic      lock_ok,
    output gate_ctl_t ctl
);
    gate_state_e st_q, st_nx;

    always_ff @(posedge osc_clk) begin
        if (rst) st_q <= (mode == MODE_PD) ? ST_RELOCK : ST_IDLE;
        else     st_q <= st_nx;
    end

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (req.sleep)     st_nx = ST_SLEEP;
                else if (!req.off) st_nx = ST_ON;
            end
            ST_ON: begin
                if (req.sleep)    st_nx = ST_SLEEP;
                else if (req.off) st_nx = ST_IDLE;
            end
            ST_SLEEP: begin
                if (!req.off) st_nx = ST_RELOCK;
            end
            ST_RELOCK: begin
                // a fresh request beats a lock arriving in the same cycle
                if (req.off)      st_nx = req.sleep ? ST_SLEEP : ST_IDLE;
                else if (lock_ok) st_nx = ST_ON;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        ctl.want_on = (st_q == ST_ON);
        ctl.standby = (st_q == ST_SLEEP);
    end
endmodule

// File: rtl/oe_out_gate.sv
module oe_out_gate (
    input  logic osc_clk,
    input  logic rst,
    input  logic kill,
    input  logic want_on,
    output logic clk_out,
    output logic drv_en,
    output logic pull_en
);
    logic gate_q;

    // Loaded on the falling edge, so the gate only opens while the clock is low.
    // The kill input clears it at once for the immediate-disable setting.
    always_ff @(negedge osc_clk or posedge kill) begin
        if (kill)     gate_q <= 1'b0;
        else if (rst) gate_q <= 1'b0;
        else          gate_q <= want_on;
    end

    assign clk_out = osc_clk & gate_q;
    assign drv_en  = gate_q;
    assign pull_en = !gate_q;
endmodule

// File: rtl/glitchfree_oe_ctl.sv
module glitchfree_oe_ctl
    import oe_ctl_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic osc_clk,
    input  logic rst,
    input  logic ctl_pin,
    input  logic mode_pd,
    input  logic timing_async,
    input  logic lock_ok,
    output logic clk_out,
    output logic drv_en,
    output logic pull_en,
    output logic standby_req
);
    pm_mode_e  mode;
    logic      pin_s;
    ctl_req_t  req_s;
    ctl_req_t  req_raw;
    gate_ctl_t ctl;
    logic      kill;

    assign mode = pm_mode_e'(mode_pd);

    oe_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .osc_clk (osc_clk),
        .rst     (rst),
        .d_in    (ctl_pin),
        .q_out   (pin_s)
    );

    assign req_s   = decode_pin(pin_s, mode);
    assign req_raw = decode_pin(ctl_pin, mode);
    assign kill    = timing_async && req_raw.off;

    oe_mode_fsm i_fsm (
        .osc_clk (osc_clk),
        .rst     (rst),
        .mode    (mode),
        .req     (req_s),
        .lock_ok (lock_ok),
        .ctl     (ctl)
    );

    oe_out_gate i_gate (
        .osc_clk (osc_clk),
        .rst     (rst),
        .kill    (kill),
        .want_on (ctl.want_on),
        .clk_out (clk_out),
        .drv_en  (drv_en),
        .pull_en (pull_en)
    );

    assign standby_req = ctl.standby;
endmodule

// File: rtl/glitchfree_oe_ctl_chk.sv
module glitchfree_oe_ctl_chk (
    input logic osc_clk,
    input logic rst,
    input logic ctl_pin,
    input logic mode_pd,
    input logic timing_async,
    input logic lock_ok,
    input logic clk_out,
    input logic drv_en,
    input logic pull_en,
    input logic standby_req
);
    // R8: gate opens only with the clock low
    always @(posedge drv_en) begin
        if (!rst) begin
            p_enable_at_fall_r8: assert (osc_clk == 1'b0)
                else $error("enable while osc_clk high");
        end
    end

    // R7: synchronous disable happens only with the clock low
    always @(negedge drv_en) begin
        if (!rst && !timing_async) begin
            p_sync_disable_at_fall_r7: assert (osc_clk == 1'b0)
                else $error("sync disable while osc_clk high");
        end
    end

    // R2: no standby request in output-enable mode
    p_no_standby_oe_r2: assert property (@(posedge osc_clk) disable iff (rst)
        standby_req |-> mode_pd);

    // R3: standby and an enabled driver never coexist a cycle later
    p_no_drive_in_standby_r3: assert property (@(posedge osc_clk) disable iff (rst)
        standby_req |=> (!drv_en || !standby_req));

    // R6: immediate disable with low pin in asynchronous setting
    p_async_off_r6: assert property (@(posedge osc_clk) disable iff (rst)
        (timing_async && !ctl_pin) |-> (!drv_en && !clk_out));

    // R5: disabled output never carries the clock
    p_quiet_when_off_r5: assert property (@(posedge osc_clk) disable iff (rst)
        pull_en |-> !clk_out);

    // R1: reset state at the edge after reset is sampled
    p_reset_state_r1: assert property (@(posedge osc_clk)
        $past(rst) && rst |-> (!standby_req && pull_en));
endmodule

bind glitchfree_oe_ctl glitchfree_oe_ctl_chk i_chk (.*);

// File: tb/test_glitchfree_oe_ctl.sv
`timescale 1ns/1ps
module test_glitchfree_oe_ctl;
    logic osc_clk = 1'b0;
    logic rst = 1'b1;
    logic ctl_pin = 1'b0;
    logic mode_pd = 1'b0;
    logic timing_async = 1'b0;
    logic lock_ok = 1'b1;
    logic clk_out, drv_en, pull_en, standby_req;

    int errors = 0;
    int checks = 0;
    int bad_rise = 0;
    int bad_sync_fall = 0;
    int runt = 0;
    realtime t_hi = 0.0;

    glitchfree_oe_ctl i_glitchfree_oe_ctl (
        .osc_clk(osc_clk), .rst(rst), .ctl_pin(ctl_pin), .mode_pd(mode_pd),
        .timing_async(timing_async), .lock_ok(lock_ok), .clk_out(clk_out),
        .drv_en(drv_en), .pull_en(pull_en), .standby_req(standby_req)
    );

    always #4 osc_clk = !osc_clk;

    // edge-position monitors for R7 and R8
    always @(posedge drv_en) if (!rst && osc_clk) bad_rise++;
    always @(negedge drv_en) if (!rst && !timing_async && osc_clk) bad_sync_fall++;
    always @(posedge clk_out) t_hi = $realtime;
    always @(negedge clk_out) if (!timing_async && ($realtime - t_hi) < 3.999) runt++;

    task automatic check(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic check_cnt(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cycles(int n);
        repeat (n) @(posedge osc_clk);
        #1;
    endtask

    task automatic do_reset(logic pd, logic as_t);
        @(posedge osc_clk); #1;
        rst = 1'b1; mode_pd = pd; timing_async = as_t; ctl_pin = 1'b0; lock_ok = 1'b1;
        cycles(3);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        @(posedge osc_clk); #1;
        rst = 1'b1; ctl_pin = 1'b1;
        cycles(3);
        #2;
        check("R1", "drv_en in reset", drv_en, 1'b0);
        check("R1", "pull_en in reset", pull_en, 1'b1);
        check("R1", "standby in reset", standby_req, 1'b0);
        check("R1", "clk_out in reset", clk_out, 1'b0);
        rst = 1'b0;
    endtask

    task automatic t_oe_sync();
        do_reset(1'b0, 1'b0);
        lock_ok = 1'b0;                      // R2: ignored in this mode
        ctl_pin = 1'b1;
        cycles(6);
        check("R2", "enable with pin high", drv_en, 1'b1);
        check("R5", "pull off when enabled", pull_en, 1'b0);
        check("R2", "standby in OE mode", standby_req, 1'b0);
        #2 check("R5", "clk_out follows osc high", clk_out, 1'b1);
        @(posedge osc_clk); #2;
        ctl_pin = 1'b0;
        #1 check("R7", "no immediate sync disable", drv_en, 1'b1);
        check("R7", "clock still high", clk_out, 1'b1);
        cycles(1);
        check("R9", "unchanged one edge later", drv_en, 1'b1);
        cycles(4);
        check("R2", "disabled with pin low", drv_en, 1'b0);
        check("R5", "pull on when disabled", pull_en, 1'b1);
        check("R2", "no standby after disable", standby_req, 1'b0);
        #2 check("R5", "clk_out held low", clk_out, 1'b0);
    endtask

    task automatic t_async_cut();
        do_reset(1'b0, 1'b1);
        ctl_pin = 1'b1;
        cycles(6);
        check("R2", "async setting enables", drv_en, 1'b1);
        @(posedge osc_clk); #1;
        ctl_pin = 1'b0;
        #1;
        check("R6", "immediate drv_en drop", drv_en, 1'b0);
        check("R6", "clk_out cut in high phase", clk_out, 1'b0);
        check("R6", "osc still high", osc_clk, 1'b1);
        // short pulse: kill meets a pending falling-edge enable
        ctl_pin = 1'b1;
        cycles(6);
        @(posedge osc_clk); #1;
        ctl_pin = 1'b0; #1 ctl_pin = 1'b1;
        #0.5 check("R6", "short pulse cut", drv_en, 1'b0);
        #1.5 check("R8", "stays off until fall", drv_en, 1'b0);
        cycles(2);
        check("R8", "re-enabled after pulse", drv_en, 1'b1);
    endtask

    task automatic t_pd();
        do_reset(1'b1, 1'b0);
        ctl_pin = 1'b1;
        cycles(6);
        check("R4", "enabled after reset with lock", drv_en, 1'b1);
        lock_ok = 1'b1;
        ctl_pin = 1'b0;
        cycles(6);
        check("R3", "standby on pin low", standby_req, 1'b1);
        check("R3", "disabled in power-down", drv_en, 1'b0);
        lock_ok = 1'b0;
        ctl_pin = 1'b1;
        cycles(6);
        check("R4", "standby released", standby_req, 1'b0);
        cycles(20);
        check("R4", "waits for lock", drv_en, 1'b0);
        lock_ok = 1'b1;
        cycles(3);
        check("R4", "enabled after lock", drv_en, 1'b1);
        // lock and new power-down collide
        ctl_pin = 1'b0;
        cycles(6);
        lock_ok = 1'b0;
        ctl_pin = 1'b1;
        cycles(6);
        ctl_pin = 1'b0;
        @(posedge osc_clk);
        @(posedge osc_clk); #1;
        lock_ok = 1'b1;
        cycles(4);
        check("R4", "power-down beats lock", standby_req, 1'b1);
        check("R4", "no enable on collision", drv_en, 1'b0);
    endtask

    task automatic t_pd_async();
        do_reset(1'b1, 1'b1);
        ctl_pin = 1'b1;
        cycles(6);
        @(posedge osc_clk); #1;
        ctl_pin = 1'b0;
        #1 check("R6", "async power-down immediate", drv_en, 1'b0);
        cycles(5);
        check("R3", "async standby", standby_req, 1'b1);
    endtask

    initial begin : watchdog
        #1000000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_oe_sync();
        t_async_cut();
        t_pd();
        t_pd_async();
        check_cnt("R8", "enables during high phase", bad_rise, 0);
        check_cnt("R7", "sync disables during high phase", bad_sync_fall, 0);
        check_cnt("R7", "runt high pulses", runt, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule